// File: doc/BRIEF.md
# Task-File Register Bus Master

This block carries out one register access at a time on an 8-bit disk task-file bus. A requester presents a 3-bit register index, a direction flag and, for a write, a byte. The block then steps through three timed phases. In the setup phase it asserts chip select and drives the address. In the strobe phase it holds the read or write strobe low. In the hold phase it releases the strobe but keeps chip select low. It then returns to idle and raises `done` for one cycle.

For a read, the byte on the data bus is latched on the last cycle of the strobe phase. That byte stays on `rdata` until the next read completes. The bidirectional data bus is presented as separate input, output and output-enable signals, so that a pad ring can combine them. The output enable is active only while a write access holds chip select low.

A second kind of request produces a drive reset. The reset line is held low for a programmable number of cycles while chip select and both strobes stay inactive. The reset line is then raised and `done` pulses. The register index is passed straight to the address pins: 0 data, 1 error/features, 2 sector count, 3 to 5 block address bytes, 6 drive/head, 7 status/command. The block does not interpret the index.

Top module: `ata_regbus_master`

## Requirements
- R1: After the synchronous active-low reset, and whenever the block is idle: `bus_cs_n`, `bus_rd_n`, `bus_wr_n` and `bus_rst_n` are 1, `bus_doe` is 0, `req_ready` is 1 and `done` is 0. `rdata` is 0 after reset.
- R2: A write (`req_write`=1) holds `bus_cs_n` low through the setup, strobe and hold phases. `bus_addr` equals the captured index and `bus_dout` the captured byte throughout. `bus_doe` is 1 throughout. `bus_wr_n` is low only in the strobe phase, and `bus_rd_n` stays high.
- R3: A read (`req_write`=0) holds `bus_cs_n` low through the same three phases with `bus_doe` at 0. `bus_rd_n` is low only in the strobe phase, and `bus_wr_n` stays high.
- R4: A read loads `rdata` with `bus_din` as sampled on the last strobe-phase cycle; the new value is visible from the first hold cycle. `rdata` changes at no other time; writes and resets leave it unchanged.
- R5: The setup, strobe and hold phases last `t_setup`, `t_strobe` and `t_hold` cycles respectively. A value of 0 behaves as 1.
- R6: `done` is 1 for exactly the one cycle after the last hold (or reset-low) cycle; the block is idle in that cycle. `req_ready` is 1 only while idle.
- R7: `req_valid` and `rst_req` are ignored while the block is not idle. The bus signals of the access in progress do not change.
- R8: A reset request drives `bus_rst_n` low for `rst_len` cycles (0 behaves as 1). During that time chip select and both strobes are high and `bus_doe` is 0. `done` then pulses.
- R9: When `rst_req` and `req_valid` are both high in an idle cycle, only the reset is performed and the access request is dropped.
- R10: `bus_doe` is 0 whenever `bus_cs_n` is 1. `bus_rst_n` stays 1 throughout every register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 3 | Task-file register index |
| req_wdata | input | 8 | Byte to write |
| rst_req | input | 1 | Drive reset request, taken when idle, wins over `req_valid` |
| t_setup | input | PH_W | Setup phase length in cycles |
| t_strobe | input | PH_W | Strobe-low phase length in cycles |
| t_hold | input | PH_W | Hold phase length in cycles |
| rst_len | input | RST_W | Reset-low length in cycles |
| req_ready | output | 1 | Block idle, request accepted on this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rst_n | output | 1 | Drive reset, active low |
| bus_addr | output | 3 | Register address lines |
| bus_dout | output | 8 | Data bus, outgoing byte |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | 8 | Data bus, incoming byte |

## Verification
A request sampled on a clock edge shows its first setup cycle right after that edge. After that come exactly max(t,1) cycles per phase. `done` follows in the cycle after the last hold cycle, and a read's new `rdata` appears from the first hold cycle. The bench turns each request into that exact list of expected per-cycle bus states at the edge that accepts it, queues the list, and pops one entry per cycle. Every entry is compared at the falling edge, so each value is checked in the cycle it is due and never at the edge where it changes. Requests raised while busy add nothing to the queue, so any reaction to them shows up as a mismatch.

// File: rtl/ata_bus_pkg.sv
// Shared types for the task-file register bus master.
// Assumes an 8-bit data path and a 3-bit register index.
package ata_bus_pkg;

    localparam int unsigned ATA_REG_W  = 3;
    localparam int unsigned ATA_DATA_W = 8;

    // Sequencer states; ST_IDLE must be the reset state.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RSTLO
    } ata_state_e;

    // Selects which programmable length is loaded into the phase timer.
    typedef enum logic [1:0] {
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } ata_phase_e;

endpackage

// File: rtl/ata_phase_timer.sv
// Down-counter for one timed phase.
// A load sets the count to len-1 (or 0 when len is 0), so the phase lasts
// max(len,1) cycles. expired is high on the final cycle of the phase.
// Assumes load is pulsed only on the edge that enters a phase.
module ata_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt;

    // Load the phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_ZERO;
        end else if (load) begin
            cnt <= (len == CNT_ZERO) ? CNT_ZERO : len - CNT_ONE;
        end else if (cnt != CNT_ZERO) begin
            cnt <= cnt - CNT_ONE;
        end
    end

    // Final cycle of the current phase.
    always_comb begin
        expired = (cnt == CNT_ZERO);
    end

endmodule

// File: rtl/ata_access_fsm.sv
// Sequencer for one register access or one drive reset.
// It captures the request in idle and then walks setup, strobe and hold,
// or the reset-low phase. It decodes the bus pins from its state and
// latches read data on the last strobe cycle.
// Assumes the timers' expired flags refer to the current phase.
module ata_access_fsm
    import ata_bus_pkg::*;
#(
    parameter int unsigned REG_W  = ATA_REG_W,
    parameter int unsigned DATA_W = ATA_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rst_req,
    input  logic              ph_expired,
    input  logic              rs_expired,
    input  logic [DATA_W-1:0] bus_din,
    output logic              ph_load,
    output ata_phase_e        ph_sel,
    output logic              rs_load,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_rst_n,
    output logic [REG_W-1:0]  bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe
);

    ata_state_e        state;
    ata_state_e        state_nxt;
    logic              cap_write;
    logic [REG_W-1:0]  cap_reg;
    logic [DATA_W-1:0] cap_data;
    logic              in_access;
    logic              finish;
    logic              take_req;

    // Next state, timer loads and phase selection.
    always_comb begin
        state_nxt = state;
        ph_load   = 1'b0;
        ph_sel    = PH_SETUP;
        rs_load   = 1'b0;
        take_req  = 1'b0;
        finish    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (rst_req) begin
                    state_nxt = ST_RSTLO;
                    rs_load   = 1'b1;
                end else if (req_valid) begin
                    state_nxt = ST_SETUP;
                    ph_load   = 1'b1;
                    ph_sel    = PH_SETUP;
                    take_req  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (ph_expired) begin
                    state_nxt = ST_STROBE;
                    ph_load   = 1'b1;
                    ph_sel    = PH_STROBE;
                end
            end
            ST_STROBE: begin
                if (ph_expired) begin
                    state_nxt = ST_HOLD;
                    ph_load   = 1'b1;
                    ph_sel    = PH_HOLD;
                end
            end
            ST_HOLD: begin
                if (ph_expired) begin
                    state_nxt = ST_IDLE;
                    finish    = 1'b1;
                end
            end
            ST_RSTLO: begin
                if (rs_expired) begin
                    state_nxt = ST_IDLE;
                    finish    = 1'b1;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // State register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nxt;
            done  <= finish;
        end
    end

    // Capture the request fields when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_write <= 1'b0;
            cap_reg   <= '0;
            cap_data  <= '0;
        end else if (take_req) begin
            cap_write <= req_write;
            cap_reg   <= req_reg;
            cap_data  <= req_wdata;
        end
    end

    // Latch the data bus on the last strobe cycle of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (state == ST_STROBE && ph_expired && !cap_write) begin
            rdata <= bus_din;
        end
    end

    // Decode the bus pins from the state.
    always_comb begin
        in_access = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        req_ready = (state == ST_IDLE);
        bus_cs_n  = !in_access;
        bus_rd_n  = !((state == ST_STROBE) && !cap_write);
        bus_wr_n  = !((state == ST_STROBE) && cap_write);
        bus_rst_n = (state != ST_RSTLO);
        bus_addr  = cap_reg;
        bus_dout  = cap_data;
        bus_doe   = in_access && cap_write;
    end

endmodule

// File: rtl/ata_regbus_master.sv
// Top level of the task-file register bus master.
// It ties the sequencer to a shared phase timer and a separate reset-length
// timer, and selects the phase length the sequencer asks for.
// Assumes the timing inputs stay stable during an access.
module ata_regbus_master
    import ata_bus_pkg::*;
#(
    parameter int unsigned PH_W  = 8,
    parameter int unsigned RST_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ATA_REG_W-1:0]  req_reg,
    input  logic [ATA_DATA_W-1:0] req_wdata,
    input  logic                  rst_req,
    input  logic [PH_W-1:0]       t_setup,
    input  logic [PH_W-1:0]       t_strobe,
    input  logic [PH_W-1:0]       t_hold,
    input  logic [RST_W-1:0]      rst_len,
    output logic                  req_ready,
    output logic                  done,
    output logic [ATA_DATA_W-1:0] rdata,
    output logic                  bus_cs_n,
    output logic                  bus_rd_n,
    output logic                  bus_wr_n,
    output logic                  bus_rst_n,
    output logic [ATA_REG_W-1:0]  bus_addr,
    output logic [ATA_DATA_W-1:0] bus_dout,
    output logic                  bus_doe,
    input  logic [ATA_DATA_W-1:0] bus_din
);

    logic            ph_load;
    logic            rs_load;
    logic            ph_expired;
    logic            rs_expired;
    ata_phase_e      ph_sel;
    logic [PH_W-1:0] ph_len;

    // Pick the programmed length of the phase being entered.
    always_comb begin
        case (ph_sel)
            PH_STROBE: ph_len = t_strobe;
            PH_HOLD:   ph_len = t_hold;
            default:   ph_len = t_setup;
        endcase
    end

    ata_access_fsm #(
        .REG_W  (ATA_REG_W),
        .DATA_W (ATA_DATA_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_reg    (req_reg),
        .req_wdata  (req_wdata),
        .rst_req    (rst_req),
        .ph_expired (ph_expired),
        .rs_expired (rs_expired),
        .bus_din    (bus_din),
        .ph_load    (ph_load),
        .ph_sel     (ph_sel),
        .rs_load    (rs_load),
        .req_ready  (req_ready),
        .done       (done),
        .rdata      (rdata),
        .bus_cs_n   (bus_cs_n),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_rst_n  (bus_rst_n),
        .bus_addr   (bus_addr),
        .bus_dout   (bus_dout),
        .bus_doe    (bus_doe)
    );

    ata_phase_timer #(.CNT_W(PH_W)) i_ph_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ph_load),
        .len     (ph_len),
        .expired (ph_expired)
    );

    ata_phase_timer #(.CNT_W(RST_W)) i_rs_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rs_load),
        .len     (rst_len),
        .expired (rs_expired)
    );

endmodule

// File: rtl/ata_regbus_checker.sv
// Protocol properties for the task-file register bus master, bound to the top.
module ata_regbus_checker #(
    parameter int unsigned PH_W  = 8,
    parameter int unsigned RST_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [2:0]       req_reg,
    input logic [7:0]       req_wdata,
    input logic             rst_req,
    input logic [PH_W-1:0]  t_setup,
    input logic [PH_W-1:0]  t_strobe,
    input logic [PH_W-1:0]  t_hold,
    input logic [RST_W-1:0] rst_len,
    input logic             req_ready,
    input logic             done,
    input logic [7:0]       rdata,
    input logic             bus_cs_n,
    input logic             bus_rd_n,
    input logic             bus_wr_n,
    input logic             bus_rst_n,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_dout,
    input logic             bus_doe,
    input logic [7:0]       bus_din
);

    p_oe_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !bus_cs_n);

    p_no_rst_in_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> bus_rst_n);

    p_strobe_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> (!bus_cs_n && (bus_rd_n || bus_wr_n)));

    p_write_drives_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_doe);

    p_read_releases_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_doe);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && bus_cs_n && bus_rst_n));

    p_addr_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !req_ready) |=> (bus_cs_n || $stable(bus_addr)));

    p_rdata_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata != $past(rdata)) |-> !$past(bus_rd_n));

    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |-> (bus_cs_n && bus_rd_n && bus_wr_n && !bus_doe));

endmodule

bind ata_regbus_master ata_regbus_checker #(.PH_W(PH_W), .RST_W(RST_W)) i_chk (.*);

// File: tb/test_ata_regbus_master.sv
module test_ata_regbus_master;

    typedef struct packed {
        logic       cs_n;
        logic       rd_n;
        logic       wr_n;
        logic       rs_n;
        logic [2:0] addr;
        logic       doe;
        logic [7:0] dout;
        logic       done;
        logic       ready;
        logic [7:0] rdata;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_reg = '0;
    logic [7:0]  req_wdata = '0;
    logic        rst_req = 1'b0;
    logic [7:0]  t_setup = 8'd1;
    logic [7:0]  t_strobe = 8'd1;
    logic [7:0]  t_hold = 8'd1;
    logic [15:0] rst_len = 16'd1;
    logic [7:0]  bus_din = '0;
    logic        req_ready;
    logic        done;
    logic [7:0]  rdata;
    logic        bus_cs_n;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic        bus_rst_n;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_dout;
    logic        bus_doe;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    bit    chk_en = 1'b0;
    string cur_tag = "R1";
    logic [7:0] exp_rdata = 8'h00;
    exp_t  q[$];

    always #5 clk = ~clk;

    ata_regbus_master i_ata_regbus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_reg(req_reg), .req_wdata(req_wdata), .rst_req(rst_req),
        .t_setup(t_setup), .t_strobe(t_strobe), .t_hold(t_hold), .rst_len(rst_len),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_rst_n(bus_rst_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din)
    );

    function automatic exp_t idle_exp(logic dn);
        exp_t e;
        e = '0;
        e.cs_n = 1'b1; e.rd_n = 1'b1; e.wr_n = 1'b1; e.rs_n = 1'b1;
        e.done = dn; e.ready = 1'b1; e.rdata = exp_rdata;
        return e;
    endfunction

    function automatic int eff(int n);
        return (n == 0) ? 1 : n;
    endfunction

    // Expected per-cycle bus states of one access, from R2 to R6.
    function automatic void push_access(bit w, logic [2:0] r, logic [7:0] d,
                                        int ns, int nw, int nh, logic [7:0] din);
        exp_t e;
        e = '0;
        e.cs_n = 1'b0; e.rd_n = 1'b1; e.wr_n = 1'b1; e.rs_n = 1'b1;
        e.addr = r; e.doe = w; e.dout = d; e.done = 1'b0; e.ready = 1'b0;
        e.rdata = exp_rdata;
        for (int i = 0; i < eff(ns); i++) q.push_back(e);
        e.rd_n = w; e.wr_n = !w;
        for (int i = 0; i < eff(nw); i++) q.push_back(e);
        if (!w) exp_rdata = din;
        e.rd_n = 1'b1; e.wr_n = 1'b1; e.rdata = exp_rdata;
        for (int i = 0; i < eff(nh); i++) q.push_back(e);
        q.push_back(idle_exp(1'b1));
    endfunction

    // Expected per-cycle bus states of a drive reset, from R8.
    function automatic void push_reset(int n);
        exp_t e;
        e = idle_exp(1'b0);
        e.rs_n = 1'b0; e.ready = 1'b0;
        for (int i = 0; i < eff(n); i++) q.push_back(e);
        q.push_back(idle_exp(1'b1));
    endfunction

    // Compare outputs with the model in the middle of every cycle.
    always @(negedge clk) begin
        if (chk_en) begin
            exp_t e;
            bit   bad;
            e = (q.size() > 0) ? q.pop_front() : idle_exp(1'b0);
            bad = (bus_cs_n !== e.cs_n) || (bus_rd_n !== e.rd_n) || (bus_wr_n !== e.wr_n)
               || (bus_rst_n !== e.rs_n) || (bus_doe !== e.doe) || (done !== e.done)
               || (req_ready !== e.ready) || (rdata !== e.rdata)
               || (!e.cs_n && bus_addr !== e.addr) || (e.doe && bus_dout !== e.dout);
            n_checks++;
            if (bad) begin
                n_errors++;
                $display("FAIL %s t=%0t act cs%b rd%b wr%b rs%b a%0d oe%b d%h dn%b rdy%b rd=%h exp cs%b rd%b wr%b rs%b a%0d oe%b d%h dn%b rdy%b rd=%h",
                    cur_tag, $time, bus_cs_n, bus_rd_n, bus_wr_n, bus_rst_n, bus_addr, bus_doe,
                    bus_dout, done, req_ready, rdata, e.cs_n, e.rd_n, e.wr_n, e.rs_n, e.addr,
                    e.doe, e.dout, e.done, e.ready, e.rdata);
            end
        end
    end

    // Watchdog: an overrun counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_errors++;
            $display("FAIL watchdog: act %0d cycles exp <= 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic issue(bit w, logic [2:0] r, logic [7:0] d, int ns, int nw, int nh,
                         logic [7:0] din);
        @(negedge clk);
        req_write = w; req_reg = r; req_wdata = d; bus_din = din;
        t_setup = 8'(ns); t_strobe = 8'(nw); t_hold = 8'(nh); req_valid = 1'b1;
        @(posedge clk);
        #1;
        push_access(w, r, d, ns, nw, nh, din);
        req_valid = 1'b0;
    endtask

    task automatic issue_reset(int n, bit with_req);
        @(negedge clk);
        rst_len = 16'(n); rst_req = 1'b1; req_valid = with_req;
        req_write = 1'b1; req_reg = 3'd7; req_wdata = 8'hEC;
        @(posedge clk);
        #1;
        push_reset(n);
        rst_req = 1'b0; req_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;
        cur_tag = "R1";                       // idle state after reset
        repeat (3) @(negedge clk);

        cur_tag = "R2";                       // write command register
        issue(1'b1, 3'd7, 8'h20, 2, 3, 2, 8'h00);
        drain();
        cur_tag = "R2";                       // write LBA byte, unit phases
        issue(1'b1, 3'd3, 8'hA5, 1, 1, 1, 8'h00);
        drain();
        cur_tag = "R3";                       // read status
        issue(1'b0, 3'd7, 8'h00, 2, 2, 2, 8'h58);
        drain();
        cur_tag = "R4";                       // second read replaces rdata
        issue(1'b0, 3'd0, 8'h00, 1, 4, 1, 8'hC3);
        drain();
        cur_tag = "R4";                       // write leaves rdata unchanged
        issue(1'b1, 3'd6, 8'hE0, 1, 2, 1, 8'h11);
        drain();
        cur_tag = "R5";                       // zero lengths behave as one
        issue(1'b0, 3'd1, 8'h00, 0, 0, 0, 8'h3C);
        drain();
        cur_tag = "R5";                       // long phases
        issue(1'b1, 3'd2, 8'h01, 7, 9, 5, 8'h00);
        drain();

        cur_tag = "R6";                       // back-to-back requests in done cycle
        issue(1'b1, 3'd4, 8'h5A, 1, 1, 1, 8'h00);
        while (q.size() > 1) @(negedge clk);
        issue(1'b0, 3'd5, 8'h00, 1, 1, 1, 8'h96);
        drain();

        cur_tag = "R7";                       // requests while busy ignored
        issue(1'b1, 3'd3, 8'h77, 5, 5, 5, 8'h00);
        @(negedge clk);
        req_valid = 1'b1; rst_req = 1'b1; req_write = 1'b0; req_reg = 3'd0; req_wdata = 8'hFF;
        repeat (4) @(negedge clk);
        req_valid = 1'b0; rst_req = 1'b0;
        drain();

        cur_tag = "R8";                       // drive reset, long
        issue_reset(20, 1'b0);
        drain();
        cur_tag = "R8";                       // drive reset, zero length
        issue_reset(0, 1'b0);
        drain();
        cur_tag = "R9";                       // reset wins over access
        issue_reset(3, 1'b1);
        drain();
        cur_tag = "R10";                      // read after reset keeps rst high
        issue(1'b0, 3'd7, 8'h00, 3, 1, 2, 8'h50);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule